// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit register file and a data memory organised as 32-bit words split into four byte lanes. On the store side it takes a register value, an access size and the two low address bits. It returns the write word with the stored bytes moved into their lanes, plus one write enable per lane. On the load side it takes the word read from memory and picks out the addressed byte, halfword or word. It then sign-extends or zero-extends the result to 32 bits.

One input selects little-endian or big-endian ordering of the bytes inside a multi-byte access. Lane `k` of the memory word always holds the byte at offset `k` within the word. Single-byte accesses therefore behave the same in both modes. Sizes and offsets that do not divide evenly raise a misalignment flag, and in that case no lane is enabled. Both paths are purely combinational, so every result is valid in the same cycle as its inputs.

Top module: `mem_lane_aligner`

## Requirements
- R1: A byte load (size code 2'b00) returns the lane at `addr_lo`. It is sign-extended from its bit 7 when `ld_unsigned` is 0 and zero-extended when it is 1.
- R2: A halfword load (size code 2'b01) assembles two lanes, `addr_lo` and `addr_lo+1`. In little-endian mode the lower lane is the low byte, and in big-endian mode it is the high byte. The value is sign-extended from bit 15, or zero-extended when `ld_unsigned` is 1.
- R3: A word load (size code 2'b10, `addr_lo`=0) returns all four lanes. In little-endian mode lane 0 is bits 7:0, and in big-endian mode lane 0 is bits 31:24.
- R4: A byte store enables exactly the one lane at `addr_lo` and places the low 8 register bits in it, in either mode.
- R5: A little-endian halfword or word store puts the least-significant register byte in the lowest addressed lane. Only the low 16 bits are used for a halfword, and all 32 for a word.
- R6: A big-endian halfword or word store puts the most-significant byte of the stored part in the lowest addressed lane.
- R7: A byte stored at an offset and loaded back from that same offset returns the same 8 bits in both endian modes.
- R8: A halfword access with `addr_lo[0]`=1, or a word access with `addr_lo`≠0, raises `misaligned`. It also forces `st_be` to 4'b0000 and `ld_data` to 0.
- R9: Size code 2'b11 is reserved. It raises `misaligned` with the same zero enables and zero load data as R8.
- R10: Every lane of `st_wdata` whose enable is 0 carries 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| big_endian | input | 1 | 1 selects big-endian ordering inside multi-byte accesses |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| addr_lo | input | 2 | Byte offset of the access within the word |
| st_data | input | 32 | Register value to be stored |
| st_wdata | output | 32 | Lane-aligned write data |
| st_be | output | 4 | Per-lane write enables, bit k for lane k |
| ld_word | input | 32 | Word returned by memory |
| ld_unsigned | input | 1 | 1 selects zero extension of narrow loads |
| ld_data | output | 32 | Aligned and extended load result |
| misaligned | output | 1 | Access size and offset do not fit together |

## Verification
There are no registers on either path. Every result is due in the same cycle its inputs are applied, which is zero clock edges later. The bench changes the inputs on the falling edge of its clock. It samples the outputs a quarter period later, well before the next rising edge, so each comparison sees settled combinational values and never a value from the previous vector. The expected words come from a byte-by-byte model of the memory addresses, built independently of how the lanes are wired.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Number of bytes an access touches; 0 for the reserved code.
  function automatic int span_of(acc_size_e s, int lanes);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return lanes;
      default: return 0;
    endcase
  endfunction

  // An access is misaligned when its offset is not a multiple of its span.
  function automatic logic misaligned_of(acc_size_e s, int offs, int lanes);
    int span;
    span = span_of(s, lanes);
    if (span == 0) return 1'b1;
    return ((offs & (span - 1)) != 0);
  endfunction

  // Which register byte feeds access byte j (j counted from lowest address).
  function automatic int reg_byte_of(int j, int span, logic big);
    return big ? (span - 1 - j) : j;
  endfunction

endpackage

// File: rtl/lsa_store_path.sv
module lsa_store_path
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              big_endian,
  input  logic              bad_access,
  input  logic [OFS_W-1:0]  offs,
  input  int                span,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_en
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      int j;
      int rb;
      logic hit;
      j   = k - int'(offs);
      hit = !bad_access && (j >= 0) && (j < span);
      rb  = reg_byte_of(j, span, big_endian);
      lane_en[k] = hit;
      if (hit && rb >= 0 && rb < LANES)
        wdata[k*LANE_W +: LANE_W] = reg_val[rb*LANE_W +: LANE_W];
      else
        wdata[k*LANE_W +: LANE_W] = '0;
    end
  end

endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              big_endian,
  input  logic              bad_access,
  input  logic [OFS_W-1:0]  offs,
  input  int                span,
  input  logic              zext,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] raw;
  logic              sign_bit;

  // Gather the addressed bytes, access byte j landing in result byte j.
  for (genvar j = 0; j < LANES; j++) begin : g_gather
    always_comb begin
      int src;
      src = big_endian ? (int'(offs) + span - 1 - j) : (int'(offs) + j);
      if (!bad_access && j < span && src >= 0 && src < LANES)
        raw[j*LANE_W +: LANE_W] = mem_word[src*LANE_W +: LANE_W];
      else
        raw[j*LANE_W +: LANE_W] = '0;
    end
  end

  always_comb begin
    sign_bit = 1'b0;
    for (int b = 0; b < DATA_W; b++)
      if (span > 0 && b == span * LANE_W - 1) sign_bit = raw[b] & !zext;
    for (int b = 0; b < DATA_W; b++)
      result[b] = (b < span * LANE_W) ? raw[b] : sign_bit;
  end

endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              big_endian,
  input  logic [1:0]        acc_size,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] st_wdata,
  output logic [LANES-1:0]  st_be,
  input  logic [DATA_W-1:0] ld_word,
  input  logic              ld_unsigned,
  output logic [DATA_W-1:0] ld_data,
  output logic              misaligned
);

  acc_size_e size_e;
  int        span;
  logic      bad_access;

  always_comb begin
    size_e     = acc_size_e'(acc_size);
    span       = span_of(size_e, LANES);
    bad_access = misaligned_of(size_e, int'(addr_lo), LANES);
  end

  assign misaligned = bad_access;

  lsa_store_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
    .big_endian (big_endian),
    .bad_access (bad_access),
    .offs       (addr_lo),
    .span       (span),
    .reg_val    (st_data),
    .wdata      (st_wdata),
    .lane_en    (st_be)
  );

  lsa_load_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
    .big_endian (big_endian),
    .bad_access (bad_access),
    .offs       (addr_lo),
    .span       (span),
    .zext       (ld_unsigned),
    .mem_word   (ld_word),
    .result     (ld_data)
  );

  // Checks across the decode and the two data paths.
  always_comb begin
    // R8
    be_off_when_bad_chk: assert (!bad_access || st_be == '0)
      else $error("enables active on misaligned access");
    // R8
    ld_zero_when_bad_chk: assert (!bad_access || ld_data == '0)
      else $error("load data nonzero on misaligned access");
    // R9
    rsvd_flagged_chk: assert (acc_size != 2'b11 || misaligned)
      else $error("reserved size not flagged");
    // R4
    byte_one_lane_chk: assert (size_e != SZ_BYTE || $countones(st_be) == 1)
      else $error("byte store enables not one lane");
    // R5
    half_two_lane_chk: assert (size_e != SZ_HALF || bad_access || $countones(st_be) == 2)
      else $error("halfword store enables not two lanes");
  end

  for (genvar k = 0; k < LANES; k++) begin : g_idle_lane
    always_comb begin
      // R10
      idle_lane_zero_chk: assert (st_be[k] || st_wdata[k*LANE_W +: LANE_W] == '0)
        else $error("disabled lane carries data");
    end
  end

endmodule

// File: tb/test_mem_lane_aligner.sv
module test_mem_lane_aligner;

  logic        clk = 1'b0;
  logic        big_endian;
  logic [1:0]  acc_size;
  logic [1:0]  addr_lo;
  logic [31:0] st_data;
  logic [31:0] st_wdata;
  logic [3:0]  st_be;
  logic [31:0] ld_word;
  logic        ld_unsigned;
  logic [31:0] ld_data;
  logic        misaligned;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mem_lane_aligner i_mem_lane_aligner (
    .big_endian (big_endian),
    .acc_size   (acc_size),
    .addr_lo    (addr_lo),
    .st_data    (st_data),
    .st_wdata   (st_wdata),
    .st_be      (st_be),
    .ld_word    (ld_word),
    .ld_unsigned(ld_unsigned),
    .ld_data    (ld_data),
    .misaligned (misaligned)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply on the falling edge, sample 5 ns later: zero-cycle combinational result.
  task automatic apply(logic be, logic [1:0] sz, logic [1:0] a, logic [31:0] sd,
                       logic [31:0] lw, logic uns);
    @(negedge clk);
    big_endian = be; acc_size = sz; addr_lo = a;
    st_data = sd; ld_word = lw; ld_unsigned = uns;
    #5;
  endtask

  function automatic int bytes_of(logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  // Model: memory address offset a+i receives register byte i (LE) or n-1-i (BE).
  task automatic store_vec(string req, logic be, logic [1:0] sz, logic [1:0] a, logic [31:0] sd);
    logic [31:0] ew = '0;
    logic [3:0]  eb = '0;
    int n = bytes_of(sz);
    for (int i = 0; i < n; i++) begin
      int rbi = be ? (n - 1 - i) : i;
      ew[(a + i) * 8 +: 8] = sd[rbi * 8 +: 8];
      eb[a + i] = 1'b1;
    end
    apply(be, sz, a, sd, 32'h0, 1'b0);
    check(req, {28'h0, st_be}, {28'h0, eb});
    check(req, st_wdata, ew);
    check(req, {31'h0, misaligned}, 32'h0);
  endtask

  // Model: assemble value by walking addresses upward.
  task automatic load_vec(string req, logic be, logic [1:0] sz, logic [1:0] a,
                          logic [31:0] lw, logic uns);
    logic [31:0] v = '0;
    int n = bytes_of(sz);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = lw[(a + i) * 8 +: 8];
      if (be) v = (v << 8) | {24'h0, b};
      else    v = v | ({24'h0, b} << (8 * i));
    end
    if (!uns && n < 4 && v[n * 8 - 1])
      for (int k = n * 8; k < 32; k++) v[k] = 1'b1;
    apply(be, sz, a, 32'h0, lw, uns);
    check(req, ld_data, v);
  endtask

  task automatic t_first_vector;
    apply(1'b0, 2'b00, 2'b00, 32'h0, 32'h0, 1'b0);
    check("R4 idle", {28'h0, st_be}, 32'h1);
    check("R1 idle", ld_data, 32'h0);
    check("R8 idle", {31'h0, misaligned}, 32'h0);
  endtask

  task automatic t_byte_loads;
    apply(1'b0, 2'b00, 2'b10, 32'h0, 32'h11_80_22_33, 1'b0);
    check("R1 signed", ld_data, 32'hFFFF_FF80);
    apply(1'b1, 2'b00, 2'b10, 32'h0, 32'h11_80_22_33, 1'b1);
    check("R1 unsigned", ld_data, 32'h0000_0080);
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 2; m++) begin
        load_vec("R1", m[0], 2'b00, a[1:0], 32'h7F_C3_05_9A, 1'b0);
        load_vec("R1", m[0], 2'b00, a[1:0], 32'h7F_C3_05_9A, 1'b1);
      end
  endtask

  task automatic t_half_loads;
    apply(1'b0, 2'b01, 2'b10, 32'h0, 32'h9A_BC_00_00, 1'b0);
    check("R2 le signed", ld_data, 32'hFFFF_9ABC);
    apply(1'b1, 2'b01, 2'b10, 32'h0, 32'h9A_BC_00_00, 1'b0);
    check("R2 be signed", ld_data, 32'hFFFF_BC9A);
    apply(1'b1, 2'b01, 2'b00, 32'h0, 32'h0000_8001, 1'b1);
    check("R2 be unsigned", ld_data, 32'h0000_0180);
    for (int m = 0; m < 2; m++)
      for (int u = 0; u < 2; u++) begin
        load_vec("R2", m[0], 2'b01, 2'b00, 32'h1234_F0E1, u[0]);
        load_vec("R2", m[0], 2'b01, 2'b10, 32'h8765_4321, u[0]);
      end
  endtask

  task automatic t_word_loads;
    apply(1'b0, 2'b10, 2'b00, 32'h0, 32'hDEAD_BEEF, 1'b0);
    check("R3 le", ld_data, 32'hDEAD_BEEF);
    apply(1'b1, 2'b10, 2'b00, 32'h0, 32'hDEAD_BEEF, 1'b1);
    check("R3 be", ld_data, 32'hEFBE_ADDE);
  endtask

  task automatic t_stores;
    apply(1'b0, 2'b01, 2'b10, 32'hFFFF_1234, 32'h0, 1'b0);
    check("R5 half", st_wdata, 32'h1234_0000);
    check("R5 half be", {28'h0, st_be}, 32'hC);
    apply(1'b1, 2'b01, 2'b10, 32'hFFFF_1234, 32'h0, 1'b0);
    check("R6 half", st_wdata, 32'h3412_0000);
    apply(1'b1, 2'b10, 2'b00, 32'hA1B2_C3D4, 32'h0, 1'b0);
    check("R6 word", st_wdata, 32'hD4C3_B2A1);
    apply(1'b0, 2'b00, 2'b11, 32'hFFFF_FF5A, 32'h0, 1'b0);
    check("R4 byte", st_wdata, 32'h5A00_0000);
    check("R10 byte", {28'h0, st_be}, 32'h8);
    for (int a = 0; a < 4; a++) begin
      store_vec("R4", 1'b0, 2'b00, a[1:0], 32'hCAFE_F00D);
      store_vec("R4", 1'b1, 2'b00, a[1:0], 32'hCAFE_F00D);
    end
    store_vec("R5", 1'b0, 2'b01, 2'b00, 32'h0102_0304);
    store_vec("R5", 1'b0, 2'b10, 2'b00, 32'h0102_0304);
    store_vec("R6", 1'b1, 2'b01, 2'b00, 32'h0102_0304);
    store_vec("R6", 1'b1, 2'b10, 2'b00, 32'h0102_0304);
  endtask

  task automatic t_invariance;
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++) begin
        logic [31:0] w;
        logic [7:0] val = 8'h80 + 8'(a * 17);
        apply(m[0], 2'b00, a[1:0], {24'hABCDEF, val}, 32'h0, 1'b0);
        w = st_wdata;
        apply(m[0], 2'b00, a[1:0], 32'h0, w, 1'b1);
        check("R7 roundtrip", ld_data, {24'h0, val});
      end
  endtask

  task automatic t_misaligned;
    logic [1:0] sz [3] = '{2'b01, 2'b10, 2'b10};
    logic [1:0] ad [3] = '{2'b11, 2'b01, 2'b10};
    for (int c = 0; c < 3; c++) begin
      apply(c[0], sz[c], ad[c], 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      check("R8 flag", {31'h0, misaligned}, 32'h1);
      check("R8 enables", {28'h0, st_be}, 32'h0);
      check("R8 ld", ld_data, 32'h0);
    end
  endtask

  task automatic t_reserved;
    for (int a = 0; a < 4; a++) begin
      apply(1'b0, 2'b11, a[1:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      check("R9 flag", {31'h0, misaligned}, 32'h1);
      check("R9 enables", {28'h0, st_be}, 32'h0);
      check("R9 ld", ld_data, 32'h0);
    end
  endtask

  initial begin
    big_endian = 0; acc_size = 0; addr_lo = 0;
    st_data = 0; ld_word = 0; ld_unsigned = 0;
    t_first_vector();
    t_byte_loads();
    t_half_loads();
    t_word_loads();
    t_stores();
    t_invariance();
    t_misaligned();
    t_reserved();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule